// File: doc/BRIEF.md
# Configuration Register Pair with Sticky Event Status

This block is the configuration-space register file of a bus-attached network controller. A simple register access port presents a dword index, four active-low byte enables, a write flag, a flag marking a configuration access, and write data. The block answers one cycle later with a response strobe, read data and a target-abort flag. The protocol engine, parity generation and the network datapath sit outside it.

Two registers are mapped. Index 0 (byte offset 0x00) is a constant identification word. Index 1 (byte offset 0x04) combines a command half and a status half. The command half is read/write and is also presented on an output for the rest of the controller. The status half latches single-cycle event pulses from the surrounding logic and from the block's own write checker. Software clears those bits by writing ones. While the command half is all zero, the block serves configuration accesses only and ignores every other access.

Top module: `cfg_space_regs`

## Requirements
- R1: A read of index 0 returns 0x884116C6, with device 0x8841 in bits 31:16 and vendor 0x16C6 in bits 15:0. A legal write to index 0 changes nothing that a later read shows.
- R2: Index 1 bits 15:0 form the command half. Only bits 0, 1, 2, 6 and 8 are stored and the rest read 0. A legal write updates only the bytes whose lanes are enabled (lane n covers bits 8n+7:8n). After reset the command half is 0 and appears on `cmd_bits`.
- R3: Status bits 31:27 are sticky. A read never clears them. A legal write to index 1 with lane 3 enabled clears each of those bits that is written with 1 and leaves each bit written with 0 unchanged. After reset they are 0.
- R4: A pulse on `ev_parity_err` sets bit 31 whatever the value of command bit 6. Pulses on `ev_sys_err`, `ev_mst_abort` and `ev_tgt_abort_rx` set bits 30, 29 and 28. If a set and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R5: Index 1 bits 26:25 always read 01 and ignore writes. Bits 24:16 read 0.
- R6: A write counts as legal only when its enabled lanes (the inverse of `acc_be_n`) are exactly one lane, lanes 0 and 1, lanes 2 and 3, or all four lanes. Any other pattern, including no lane at all, leaves every register unchanged. It also raises `rsp_abort` for one response cycle and sets status bit 27 at the same clock edge.
- R7: A read is accepted with any byte-enable pattern and always returns the full dword.
- R8: While the command half is 0, an access with `acc_cfg` low gets no response (`rsp_valid` stays low), writes nothing and raises no abort. Once the command half is non-zero such accesses are served.
- R9: Every accepted access produces `rsp_valid` exactly one clock after it is sampled. `rsp_rdata` carries the read value, or 0 for a write or for an unmapped index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request, sampled on each rising edge |
| acc_cfg | input | 1 | Access is a configuration access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_idx | input | 6 | Dword index (byte offset / 4) |
| acc_be_n | input | 4 | Active-low byte-lane enables |
| acc_wdata | input | 32 | Write data |
| ev_parity_err | input | 1 | Parity-error event pulse |
| ev_sys_err | input | 1 | System-error-asserted event pulse |
| ev_mst_abort | input | 1 | Master-abort-received event pulse |
| ev_tgt_abort_rx | input | 1 | Target-abort-received event pulse |
| rsp_valid | output | 1 | Response strobe for an accepted access |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_abort | output | 1 | Write rejected with a target abort |
| cmd_bits | output | 16 | Current command half |

## Verification
The bench sweeps all sixteen byte-enable patterns of a write to the command/status register. A design that accepts a misaligned word or an empty enable would corrupt the command half or clear status bits, and would miss the abort and bit 27. A set pulse is driven in the same cycle as a write-one clear of that bit, where a design giving priority to the clear loses the event. Bench cases also cover a parity event with the response enable off, a read that must leave status intact, and zero-written status bits. The refusal window is tested with non-configuration reads and writes before and after the command half becomes non-zero. A design that ignores it would answer, or would let such a write enable itself.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned HW     = 16;
  localparam int unsigned LANES  = 4;
  localparam int unsigned EV_N   = 5;   // status bits 31..27
  localparam int unsigned EV_LSB = 27;
  localparam int unsigned RSV_W  = 9;   // status bits 24..16
  localparam logic [1:0]  DSEL_TIMING = 2'b01;

  typedef enum logic [1:0] {
    SEL_IDENT = 2'd0,
    SEL_CMDST = 2'd1,
    SEL_NONE  = 2'd2
  } reg_sel_e;

  // enabled-lane masks a write may use
  function automatic logic lanes_legal(input logic [LANES-1:0] en);
    case (en)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: lanes_legal = 1'b1;
      default:                   lanes_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_be_check.sv
module cfg_be_check
  import cfgsp_pkg::*;
(
  input  logic [LANES-1:0] be_n,
  output logic [LANES-1:0] lane_en,
  output logic             legal
);
  always_comb begin
    lane_en = ~be_n;
    legal   = lanes_legal(lane_en);
  end
endmodule

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg #(
  parameter int unsigned   WIDTH = 16,
  parameter logic [15:0]   KEEP  = 16'h0147
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH/8-1:0] lane_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned NLANE = WIDTH / 8;

  logic [WIDTH-1:0] q_nxt;
  logic [WIDTH-1:0] q_r;

  for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
    for (genvar b = 0; b < 8; b++) begin : g_bit
      localparam int unsigned IX = ln * 8 + b;
      if (KEEP[IX]) begin : g_store
        always_comb begin
          q_nxt[IX] = q_r[IX];
          if (we && lane_en[ln]) q_nxt[IX] = wdata[IX];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  q_r[IX] <= 1'b0;
          else         q_r[IX] <= q_nxt[IX];
        end
      end else begin : g_zero
        assign q_nxt[IX] = 1'b0;
        assign q_r[IX]   = 1'b0;
      end
    end
  end

  assign q = q_r;
endmodule

// File: rtl/cfg_event_bits.sv
module cfg_event_bits #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_nxt;

  for (genvar i = 0; i < N; i++) begin : g_ev
    // a set in the same cycle as a clear keeps the bit
    always_comb q_nxt[i] = set[i] | (q_r[i] & ~clr[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q_r[i] <= 1'b0;
      else if (set[i] || clr[i])       q_r[i] <= q_nxt[i];
    end
  end

  assign q = q_r;
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfgsp_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter logic [15:0] DEV_ID   = 16'h8841,
  parameter logic [15:0] VEN_ID   = 16'h16C6,
  parameter logic [15:0] CMD_KEEP = 16'h0147
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_cfg,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [3:0]       acc_be_n,
  input  logic [31:0]      acc_wdata,
  input  logic             ev_parity_err,
  input  logic             ev_sys_err,
  input  logic             ev_mst_abort,
  input  logic             ev_tgt_abort_rx,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_abort,
  output logic [15:0]      cmd_bits
);
  localparam logic [IDX_W-1:0] IDX_IDENT = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CMDST = IDX_W'(1);
  localparam logic [DW-1:0]    IDENT     = {DEV_ID, VEN_ID};

  logic [LANES-1:0] lane_en;
  logic             be_ok;
  logic [HW-1:0]    cmd_q;
  logic [EV_N-1:0]  stat_q;
  logic [EV_N-1:0]  stat_set;
  logic [EV_N-1:0]  stat_clr;
  reg_sel_e         sel;
  logic             refuse, take, wr_ok, wr_bad, cmd_we;
  logic [DW-1:0]    rd_word;

  cfg_be_check u_be (
    .be_n    (acc_be_n),
    .lane_en (lane_en),
    .legal   (be_ok)
  );

  always_comb begin
    if (acc_idx == IDX_IDENT)      sel = SEL_IDENT;
    else if (acc_idx == IDX_CMDST) sel = SEL_CMDST;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    refuse = acc_valid && !acc_cfg && (cmd_q == '0);
    take   = acc_valid && !refuse;
    wr_ok  = take && acc_write && be_ok;
    wr_bad = take && acc_write && !be_ok;
    cmd_we = wr_ok && (sel == SEL_CMDST);
  end

  cfg_cmd_reg #(.WIDTH(HW), .KEEP(CMD_KEEP)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cmd_we),
    .lane_en (lane_en[HW/8-1:0]),
    .wdata   (acc_wdata[HW-1:0]),
    .q       (cmd_q)
  );

  always_comb begin
    stat_set = {ev_parity_err, ev_sys_err, ev_mst_abort, ev_tgt_abort_rx, wr_bad};
    stat_clr = '0;
    if (cmd_we && lane_en[LANES-1]) stat_clr = acc_wdata[DW-1:EV_LSB];
  end

  cfg_event_bits #(.N(EV_N)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (stat_set),
    .clr   (stat_clr),
    .q     (stat_q)
  );

  always_comb begin
    case (sel)
      SEL_IDENT: rd_word = IDENT;
      SEL_CMDST: rd_word = {stat_q, DSEL_TIMING, {RSV_W{1'b0}}, cmd_q};
      default:   rd_word = '0;
    endcase
  end

  // response stage
  logic          rsp_valid_d, rsp_abort_d;
  logic [DW-1:0] rsp_rdata_d;
  logic          rsp_valid_q, rsp_abort_q;
  logic [DW-1:0] rsp_rdata_q;

  always_comb begin
    rsp_valid_d = take;
    rsp_abort_d = wr_bad;
    rsp_rdata_d = acc_write ? '0 : rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_abort_q <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_abort_q <= rsp_abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rsp_rdata_q <= '0;
    else if (take) rsp_rdata_q <= rsp_rdata_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_abort = rsp_abort_q;
  assign rsp_rdata = rsp_rdata_q;
  assign cmd_bits  = cmd_q;
endmodule

module cfg_space_regs_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_cfg,
  input logic             acc_write,
  input logic [IDX_W-1:0] acc_idx,
  input logic             ev_parity_err,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_abort,
  input logic [15:0]      cmd_q,
  input logic [4:0]       stat_q
);
  p_ident_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!acc_write && acc_idx == '0)) |-> rsp_rdata == 32'h884116C6);

  p_cmd_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> $past(acc_valid && acc_write));

  p_sticky_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_q) & ~stat_q)) |-> $past(acc_valid && acc_write));

  p_parity_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_parity_err) |-> stat_q[4]);

  p_dsel_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!acc_write && acc_idx == 1)) |-> rsp_rdata[26:16] == 11'h200);

  p_abort_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |-> (stat_q[0] && rsp_valid));

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && !acc_cfg && cmd_q == '0) |-> (!rsp_valid && !rsp_abort));

  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid));
endmodule

bind cfg_space_regs cfg_space_regs_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_cfg       (acc_cfg),
  .acc_write     (acc_write),
  .acc_idx       (acc_idx),
  .ev_parity_err (ev_parity_err),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .rsp_abort     (rsp_abort),
  .cmd_q         (cmd_q),
  .stat_q        (stat_q)
);

// File: tb/test_cfg_space_regs.sv
module test_cfg_space_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_cfg = 1'b0, acc_write = 1'b0;
  logic [5:0]  acc_idx = '0;
  logic [3:0]  acc_be_n = 4'hF;
  logic [31:0] acc_wdata = '0;
  logic        ev_par = 1'b0, ev_sys = 1'b0, ev_mab = 1'b0, ev_tab = 1'b0;
  logic        rsp_valid, rsp_abort;
  logic [31:0] rsp_rdata;
  logic [15:0] cmd_bits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] cmd_m;
  logic [4:0]  stat_m;
  localparam logic [15:0] KEEP = 16'h0147;

  always #4 clk = ~clk;

  cfg_space_regs i_cfg_space_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_cfg(acc_cfg),
    .acc_write(acc_write), .acc_idx(acc_idx), .acc_be_n(acc_be_n),
    .acc_wdata(acc_wdata), .ev_parity_err(ev_par), .ev_sys_err(ev_sys),
    .ev_mst_abort(ev_mab), .ev_tgt_abort_rx(ev_tab), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort), .cmd_bits(cmd_bits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [3:0] en);
    int n = $countones(en);
    return (n == 1) || (n == 4) || (n == 2 && (en == 4'b0011 || en == 4'b1100));
  endfunction

  function automatic logic [31:0] cs_word();
    return {stat_m, 2'b01, 9'b0, cmd_m};
  endfunction

  // drive one access; outputs sampled one edge later at the following negedge
  task automatic access(input bit cfg, input bit wr, input logic [5:0] idx,
                        input logic [3:0] be_n, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_cfg = cfg; acc_write = wr;
    acc_idx = idx; acc_be_n = be_n; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; ev_par = 1'b0; ev_sys = 1'b0; ev_mab = 1'b0; ev_tab = 1'b0;
  endtask

  // reference update for a served write to index 1
  task automatic model_write(input logic [3:0] be_n, input logic [31:0] wd, input logic [4:0] ev);
    logic [3:0] en = ~be_n;
    logic [4:0] clr = '0;
    if (legal(en)) begin
      for (int ln = 0; ln < 2; ln++)
        if (en[ln]) cmd_m[ln*8 +: 8] = wd[ln*8 +: 8] & KEEP[ln*8 +: 8];
      if (en[3]) clr = wd[31:27];
    end
    stat_m = ev | (legal(en) ? 5'b0 : 5'b00001) | (stat_m & ~clr);
  endtask

  task automatic pulse_events(input logic [3:0] ev);
    @(negedge clk);
    {ev_par, ev_sys, ev_mab, ev_tab} = ev;
    @(negedge clk);
    {ev_par, ev_sys, ev_mab, ev_tab} = 4'b0;
    stat_m = stat_m | {ev, 1'b0};
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cmd_m = '0; stat_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 reset state
    check("R2 reset cmd_bits", {16'h0, cmd_bits}, 32'h0);
    access(1, 0, 6'd1, 4'h0, 0);
    check("R9 rsp_valid on read", {31'b0, rsp_valid}, 32'h1);
    check("R3 R5 reset cmd/status", rsp_rdata, 32'h0200_0000);

    // R8 refusal while command half is zero
    access(0, 0, 6'd0, 4'h0, 0);
    check("R8 refused read no rsp", {31'b0, rsp_valid}, 32'h0);
    access(0, 1, 6'd1, 4'h0, 32'hFFFF_FFFF);
    check("R8 refused write no abort", {30'b0, rsp_valid, rsp_abort}, 32'h0);
    check("R8 refused write no effect", {16'h0, cmd_bits}, 32'h0);

    // R1 identification, R7 any enables on read
    for (int b = 0; b < 16; b++) begin
      access(1, 0, 6'd0, 4'(b), 0);
      check("R1 R7 ident read", rsp_rdata, 32'h8841_16C6);
    end
    access(1, 1, 6'd0, 4'h0, 32'h0);
    check("R9 write rdata zero", rsp_rdata, 32'h0);
    access(1, 0, 6'd0, 4'h0, 0);
    check("R1 ident after write", rsp_rdata, 32'h8841_16C6);
    access(1, 0, 6'd9, 4'h0, 0);
    check("R9 unmapped read zero", rsp_rdata, 32'h0);

    // R6 R2 R3 byte-enable sweep on index 1
    for (int b = 0; b < 16; b++) begin
      logic [3:0]  en = 4'(b);
      logic [31:0] wd = 32'hF800_0000 | {16'h0, 16'(b * 16'h1111) ^ 16'hFFFF};
      pulse_events(4'b1111);
      access(1, 1, 6'd1, ~en, wd);
      model_write(~en, wd, 5'b0);
      check("R6 abort on enable pattern", {31'b0, rsp_abort}, {31'b0, !legal(en)});
      access(1, 0, 6'd1, ~en, 0);
      check("R2 R3 R6 readback after write", rsp_rdata, cs_word());
    end

    // R8 served once command non-zero
    access(1, 1, 6'd1, 4'b1100, 32'h0000_0001);
    model_write(4'b1100, 32'h0000_0001, 5'b0);
    access(0, 0, 6'd1, 4'h0, 0);
    check("R8 non-config served", {31'b0, rsp_valid}, 32'h1);
    check("R8 non-config data", rsp_rdata, cs_word());

    // R4 parity with command bit 6 clear, R3 read does not clear
    check("R4 cmd bit6 clear", {31'b0, cmd_bits[6]}, 32'h0);
    pulse_events(4'b1000);
    access(1, 0, 6'd1, 4'h0, 0);
    check("R4 parity sets bit31", rsp_rdata, cs_word());
    access(1, 0, 6'd1, 4'h0, 0);
    check("R3 read keeps status", rsp_rdata, cs_word());

    // R3 write zero leaves, write one clears single bit
    pulse_events(4'b0110);
    access(1, 1, 6'd1, 4'b0111, 32'h0000_0000);
    model_write(4'b0111, 32'h0, 5'b0);
    access(1, 0, 6'd1, 4'h0, 0);
    check("R3 write zero keeps", rsp_rdata, cs_word());
    access(1, 1, 6'd1, 4'b0111, 32'h4000_0000);
    model_write(4'b0111, 32'h4000_0000, 5'b0);
    access(1, 0, 6'd1, 4'h0, 0);
    check("R3 clear bit30 only", rsp_rdata, cs_word());

    // R4 set beats clear in the same cycle
    ev_par = 1'b1; ev_mab = 1'b1;
    access(1, 1, 6'd1, 4'b0111, 32'hFFFF_FFFF);
    model_write(4'b0111, 32'hFFFF_FFFF, 5'b10100);
    access(1, 0, 6'd1, 4'h0, 0);
    check("R4 set wins over clear", rsp_rdata, cs_word());

    // R5 fixed field ignores writes
    access(1, 1, 6'd1, 4'b0000, 32'h0000_0000);
    model_write(4'b0000, 32'h0, 5'b0);
    access(1, 0, 6'd1, 4'h0, 0);
    check("R5 timing field fixed", rsp_rdata, cs_word());

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule